// File: doc/BRIEF.md
# Debug Trace Capture Controller

This block records a running history of processor activity into a 64-entry on-chip circular store, so that software can later see what happened around an event of interest. Each clock it looks at a per-cycle bus monitor: bus address, bus data, a valid-cycle flag, an opcode-fetch flag, an instruction-boundary strobe, a change-of-flow pulse and the program counter. A mode select decides which cycles become entries. The modes are change-of-flow sources, change-of-flow sources with repeats removed, every non-fetch data access, or every program counter value.

A session starts with a one-cycle `arm` pulse. This empties the store and resets the read position. The trigger input then fixes where recording stops. The trigger can sit at the start of the record, in its middle, or at its end. While the secure flag is high the block records nothing and ignores the trigger. After the session, software pulls the record out through a 16-bit read window, one word per read pulse, oldest entry first.

The controller has four named states:
- IDLE is the state after reset.
- ARMED is entered from any state on `arm`.
- POST is entered from ARMED when the trigger is accepted with start or middle alignment.
- DONE is entered from POST once the post-trigger quota is stored, or from ARMED directly when the trigger is accepted with end alignment.

DONE is left only by a new `arm`.

Top module: `trace_capture_ctrl`

## Requirements
- R1: After reset and before any `arm`, nothing is stored, and `rd_data` reads 0000 even after read pulses.
- R2: An `arm` pulse empties the store, returns the read position to the first word and moves the controller to ARMED.
- R3: Mode code 0 (flow) stores one entry for each cycle with `cof` high. The first word is `pc` and the second word is 0000.
- R4: Mode code 1 (loop) behaves like mode 0. It stores no entry when `pc` equals the source of the last entry stored in this session.
- R5: Mode code 2 (detail) stores one entry for each cycle with `bus_valid` high and `bus_opfetch` low. The first word is `bus_addr` and the second word is `bus_data`.
- R6: Mode code 3 (program counter) stores one entry for each cycle with `pc_stb` high. The first word is `pc` and the second word is 0000.
- R7: Alignment code 0 (start) stores nothing before the trigger. The entry of the trigger cycle is stored first, and recording stops after 64 entries.
- R8: Alignment code 1 (middle) records before the trigger. It stops once 32 entries, counting the trigger-cycle entry, have been stored from the trigger on.
- R9: Alignment code 2 (end), and the reserved code 3, stop recording with the trigger-cycle entry as the last one stored.
- R10: The store wraps and keeps only the latest 64 entries.
- R11: Each cycle with `rd_en` high advances the read window by one 16-bit word. Words come oldest entry first, the first word of an entry before its second. Once the window is past the last stored word it reads 0000 and no longer advances.
- R12: While `secure` is high, no entry is stored and the trigger has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Start a new session |
| trig | input | 1 | Trigger event |
| mode | input | 2 | Capture mode code |
| align | input | 2 | Trigger alignment code |
| secure | input | 1 | Secured state, blocks tracing |
| pc_stb | input | 1 | Instruction boundary strobe |
| cof | input | 1 | Change-of-flow pulse, `pc` holds its source |
| pc | input | 16 | Program counter |
| bus_valid | input | 1 | Non-free bus cycle |
| bus_opfetch | input | 1 | Bus cycle is an opcode fetch |
| bus_addr | input | 16 | Bus address |
| bus_data | input | 16 | Bus data |
| rd_en | input | 1 | Read pulse, advances the window |
| rd_data | output | 16 | Read window word |

## Verification
The trigger acceptance and the storing of a qualifying entry can fall in the same cycle. The alignment rules hinge on whether that entry counts as the first or the last one. The stimulus table places triggers on cycles where `cof`, `pc_stb` or a valid data cycle is also active. In one loop-mode row the trigger cycle is itself a suppressed repeat. The readback is compared with a reference model that stores the trigger-cycle entry under the rules of R7 to R9. A second coincidence, a secure window that covers the trigger, must leave recording running with no stop.

// File: rtl/trc_pkg.sv
package trc_pkg;
    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        TM_FLOW   = 2'd0,
        TM_LOOP   = 2'd1,
        TM_DETAIL = 2'd2,
        TM_PC     = 2'd3
    } trc_mode_e;

    localparam logic [1:0] AL_BEGIN = 2'd0;
    localparam logic [1:0] AL_MID   = 2'd1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_POST  = 2'd2,
        ST_DONE  = 2'd3
    } trc_state_e;
endpackage

// File: rtl/trc_qualify.sv
module trc_qualify
    import trc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  arm,
    input  trc_mode_e             mode,
    input  logic                  pc_stb,
    input  logic                  cof,
    input  logic [WORD_W-1:0]     pc,
    input  logic                  bus_valid,
    input  logic                  bus_opfetch,
    input  logic [WORD_W-1:0]     bus_addr,
    input  logic [WORD_W-1:0]     bus_data,
    input  logic                  wr_en,
    output logic                  qual,
    output logic [2*WORD_W-1:0]   entry
);
    logic [WORD_W-1:0] last_src;
    logic              last_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_src <= '0;
            last_v   <= 1'b0;
        end else if (arm) begin
            last_v   <= 1'b0;
        end else if (wr_en && mode == TM_LOOP) begin
            last_src <= pc;
            last_v   <= 1'b1;
        end
    end

    always_comb begin
        qual  = 1'b0;
        entry = {pc, {WORD_W{1'b0}}};
        unique case (mode)
            TM_FLOW:   qual = cof;
            TM_LOOP:   qual = cof && !(last_v && pc == last_src);
            TM_DETAIL: begin
                qual  = bus_valid && !bus_opfetch;
                entry = {bus_addr, bus_data};
            end
            TM_PC:     qual = pc_stb;
        endcase
    end

    // R4
    loop_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TM_LOOP && last_v && pc == last_src) |-> !qual);
endmodule

// File: rtl/trc_seq.sv
module trc_seq
    import trc_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm,
    input  logic       trig,
    input  logic [1:0] align,
    input  logic       secure,
    input  logic       qual,
    output logic       wr_en
);
    localparam int CW = $clog2(DEPTH) + 1;

    trc_state_e     st, nxt;
    logic [CW-1:0]  post_cnt;
    logic [CW-1:0]  limit;
    logic           trig_ok;

    assign trig_ok = trig && !secure;
    assign limit   = (align == AL_BEGIN) ? CW'(DEPTH) : CW'(DEPTH / 2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      post_cnt <= '0;
        else if (arm)                    post_cnt <= '0;
        else if (st == ST_ARMED && trig_ok) post_cnt <= wr_en ? CW'(1) : '0;
        else if (st == ST_POST && wr_en) post_cnt <= post_cnt + 1'b1;
    end

    always_comb begin
        nxt   = st;
        wr_en = 1'b0;
        unique case (st)
            ST_IDLE: ;
            ST_ARMED: begin
                wr_en = qual && !secure && (align != AL_BEGIN || trig_ok);
                if (trig_ok)
                    nxt = (align == AL_BEGIN || align == AL_MID) ? ST_POST : ST_DONE;
            end
            ST_POST: begin
                wr_en = qual && !secure;
                if (wr_en && post_cnt == limit - 1'b1) nxt = ST_DONE;
            end
            ST_DONE: ;
        endcase
        if (arm) begin
            nxt   = ST_ARMED;
            wr_en = 1'b0;
        end
    end

    // R9
    end_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ARMED && trig && !secure && !arm && align[1]) |=> st == ST_DONE);
    // R2
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DONE && !arm) |=> st == ST_DONE);
    // R7
    begin_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ARMED && align == AL_BEGIN && !trig) |-> !wr_en);
endmodule

// File: rtl/trc_store.sv
module trc_store
    import trc_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  arm,
    input  logic                  wr_en,
    input  logic [2*WORD_W-1:0]   entry,
    input  logic                  rd_en,
    output logic [WORD_W-1:0]     rd_data
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam int RW = AW + 2;

    logic [2*WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]       wr_ptr;
    logic [CW-1:0]       count;
    logic [RW-1:0]       rd_ptr;
    logic [AW-1:0]       oldest, idx;
    logic                in_range;
    logic [2*WORD_W-1:0] sel;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= entry;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            count  <= '0;
        end else if (arm) begin
            wr_ptr <= '0;
            count  <= '0;
        end else if (wr_en) begin
            wr_ptr <= wr_ptr + 1'b1;
            if (count != CW'(DEPTH)) count <= count + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                rd_ptr <= '0;
        else if (arm)              rd_ptr <= '0;
        else if (rd_en && in_range) rd_ptr <= rd_ptr + 1'b1;
    end

    assign oldest   = wr_ptr - count[AW-1:0];
    assign idx      = oldest + rd_ptr[AW:1];
    assign in_range = rd_ptr < {count, 1'b0};
    assign sel      = mem[idx];
    assign rd_data  = !in_range ? '0 : (rd_ptr[0] ? sel[WORD_W-1:0] : sel[2*WORD_W-1:WORD_W]);

    // R10
    count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R11
    rd_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !arm && in_range) |=> rd_ptr == $past(rd_ptr) + 1'b1);
    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_range && !arm && !wr_en) |=> $stable(rd_ptr));
endmodule

// File: rtl/trace_capture_ctrl.sv
module trace_capture_ctrl
    import trc_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        arm,
    input  logic        trig,
    input  logic [1:0]  mode,
    input  logic [1:0]  align,
    input  logic        secure,
    input  logic        pc_stb,
    input  logic        cof,
    input  logic [15:0] pc,
    input  logic        bus_valid,
    input  logic        bus_opfetch,
    input  logic [15:0] bus_addr,
    input  logic [15:0] bus_data,
    input  logic        rd_en,
    output logic [15:0] rd_data
);
    logic                qual;
    logic                wr_en;
    logic [2*WORD_W-1:0] entry;

    trc_qualify u_qual (
        .clk(clk), .rst_n(rst_n), .arm(arm), .mode(trc_mode_e'(mode)),
        .pc_stb(pc_stb), .cof(cof), .pc(pc), .bus_valid(bus_valid),
        .bus_opfetch(bus_opfetch), .bus_addr(bus_addr), .bus_data(bus_data),
        .wr_en(wr_en), .qual(qual), .entry(entry)
    );

    trc_seq #(.DEPTH(DEPTH)) u_seq (
        .clk(clk), .rst_n(rst_n), .arm(arm), .trig(trig), .align(align),
        .secure(secure), .qual(qual), .wr_en(wr_en)
    );

    trc_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .arm(arm), .wr_en(wr_en), .entry(entry),
        .rd_en(rd_en), .rd_data(rd_data)
    );

    // R12
    secure_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (secure && !arm && !rd_en) |=> $stable(rd_data));
endmodule

// File: tb/trace_capture_ctrl_tb.sv
module trace_capture_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int D = 64;
    localparam int NROWS = 8;

    typedef struct packed {
        logic [1:0]  md;
        logic [1:0]  al;
        logic [15:0] tc;
        logic [15:0] n;
        logic [15:0] s0;
        logic [15:0] s1;
    } row_t;

    // mode, align, trigger cycle, length, secure from, secure to
    localparam row_t ROWS [NROWS] = '{
        '{2'd0, 2'd0, 16'd10,  16'd250, 16'd0,  16'd0},
        '{2'd1, 2'd2, 16'd120, 16'd150, 16'd0,  16'd0},
        '{2'd2, 2'd1, 16'd100, 16'd200, 16'd0,  16'd0},
        '{2'd3, 2'd2, 16'd30,  16'd40,  16'd0,  16'd0},
        '{2'd3, 2'd0, 16'd5,   16'd300, 16'd20, 16'd40},
        '{2'd2, 2'd2, 16'd50,  16'd200, 16'd45, 16'd55},
        '{2'd1, 2'd1, 16'd40,  16'd200, 16'd0,  16'd0},
        '{2'd0, 2'd3, 16'd60,  16'd90,  16'd0,  16'd0}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic arm = 0, trig = 0, secure = 0, pc_stb = 0, cof = 0;
    logic bus_valid = 0, bus_opfetch = 0, rd_en = 0;
    logic [1:0] mode = 0, align = 0;
    logic [15:0] pc = 0, bus_addr = 0, bus_data = 0;
    logic [15:0] rd_data;

    int checks = 0, errors = 0;
    logic [31:0] mmem [D];
    int mwp, mcnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    trace_capture_ctrl #(.DEPTH(D)) u_dut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .trig(trig), .mode(mode),
        .align(align), .secure(secure), .pc_stb(pc_stb), .cof(cof), .pc(pc),
        .bus_valid(bus_valid), .bus_opfetch(bus_opfetch), .bus_addr(bus_addr),
        .bus_data(bus_data), .rd_en(rd_en), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_bus();
        trig = 0; secure = 0; pc_stb = 0; cof = 0; bus_valid = 0; bus_opfetch = 0;
    endtask

    task automatic do_arm();
        @(negedge clk); idle_bus(); arm = 1;
        @(negedge clk); arm = 0;
        mwp = 0; mcnt = 0;
    endtask

    task automatic run_row(input row_t r);
        int mst = 1;          // 1 armed, 2 post, 3 done
        int post = 0;
        int lim;
        logic [15:0] last = 0;
        logic lastv = 0;
        logic q, tr, st_ok;
        logic [31:0] ent;
        lim = (r.al == 2'd0) ? D : D / 2;
        mode = r.md; align = r.al;
        do_arm();
        for (int i = 0; i < int'(r.n); i++) begin
            cof = (i % 3 == 0);
            pc_stb = (i % 5 != 4);
            pc = 16'h4000 + 16'((i / 9) * 16);
            bus_valid = (i % 4 != 3);
            bus_opfetch = (i % 3 == 1);
            bus_addr = 16'h8000 + 16'(i);
            bus_data = 16'hA500 ^ 16'(i * 7);
            secure = (i >= int'(r.s0)) && (i < int'(r.s1));
            trig = (i == int'(r.tc));
            case (r.md)
                2'd0: begin q = cof; ent = {pc, 16'h0}; end
                2'd1: begin q = cof && !(lastv && pc == last); ent = {pc, 16'h0}; end
                2'd2: begin q = bus_valid && !bus_opfetch; ent = {bus_addr, bus_data}; end
                default: begin q = pc_stb; ent = {pc, 16'h0}; end
            endcase
            tr = trig && !secure;
            st_ok = !secure && q &&
                    ((mst == 1 && (r.al != 2'd0 || tr)) || mst == 2);
            if (st_ok) begin
                mmem[mwp] = ent;
                mwp = (mwp + 1) % D;
                if (mcnt < D) mcnt++;
                if (r.md == 2'd1) begin last = pc; lastv = 1; end
            end
            if (mst == 1 && tr) begin
                mst = (r.al == 2'd0 || r.al == 2'd1) ? 2 : 3;
                post = st_ok ? 1 : 0;
            end else if (mst == 2 && st_ok) begin
                post++;
                if (post == lim) mst = 3;
            end
            @(negedge clk);
        end
        idle_bus();
    endtask

    task automatic read_all(input string tag);
        logic [31:0] e;
        logic [15:0] exp;
        for (int k = 0; k < 2 * D + 2; k++) begin
            if (k < 2 * mcnt) begin
                e = mmem[(mwp - mcnt + k / 2 + D) % D];
                exp = (k % 2 == 0) ? e[31:16] : e[15:0];
            end else begin
                exp = 16'h0;
            end
            check($sformatf("%s word %0d", tag, k), rd_data, exp);
            rd_en = 1;
            @(negedge clk);
        end
        rd_en = 0;
    endtask

    function automatic string row_tag(input row_t r);
        string s;
        case (r.md)
            2'd0: s = "R3";
            2'd1: s = "R4";
            2'd2: s = "R5";
            default: s = "R6";
        endcase
        case (r.al)
            2'd0: s = {s, " R7"};
            2'd1: s = {s, " R8"};
            default: s = {s, " R9"};
        endcase
        s = {s, " R10 R11"};
        if (r.s1 != 0) s = {s, " R12"};
        return s;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: nothing stored after reset, reads stay zero
        check("R1 reset window", rd_data, 16'h0);
        rd_en = 1; @(negedge clk); @(negedge clk); rd_en = 0;
        check("R1 reset window after reads", rd_data, 16'h0);
        // R1: traffic before any arm is not recorded
        mode = 2'd3; pc_stb = 1; pc = 16'h1234; trig = 1;
        repeat (4) @(negedge clk);
        idle_bus();
        check("R1 no capture before arm", rd_data, 16'h0);

        for (int r = 0; r < NROWS; r++) begin
            run_row(ROWS[r]);
            read_all(row_tag(ROWS[r]));
        end

        // R2: arm empties a filled store
        do_arm();
        check("R2 cleared after arm", rd_data, 16'h0);

        // R12: secure held for a whole session leaves the store empty
        mode = 2'd3; align = 2'd1;
        @(negedge clk);
        secure = 1; pc_stb = 1; pc = 16'h7777; trig = 1;
        repeat (10) @(negedge clk);
        idle_bus();
        check("R12 nothing stored while secure", rd_data, 16'h0);

        // R7 and R11: start alignment, one entry then window order and end
        do_arm();
        mode = 2'd0; align = 2'd0;
        cof = 1; pc = 16'hBEEF; trig = 0;
        @(negedge clk);
        check("R7 no entry before trigger", rd_data, 16'h0);
        pc = 16'hCAFE; trig = 1;
        @(negedge clk);
        idle_bus();
        check("R11 first word of first entry", rd_data, 16'hCAFE);
        rd_en = 1; @(negedge clk);
        check("R11 second word", rd_data, 16'h0000);
        @(negedge clk); rd_en = 0;
        check("R11 past end reads zero", rd_data, 16'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule